// File: doc/BRIEF.md
# Registered Parity Bus Transceiver

This block joins two 18-bit buses, an A side and a B side. Each bus is split into two 9-bit lanes, and each lane carries one data byte plus one parity bit. Each direction, A-to-B and B-to-A, has its own storage stage. Each lane of a stage can be transparent, can hold its value, or can capture on the direction's clock edge under its own lane clock enable.

When the bypass control is low, the block works on parity. Each outgoing lane gets a parity bit recomputed from its stored byte. At the same time, the stored nine bits of every lane are checked against the selected parity sense, and the result appears as an active-low error flag per lane and per side. When bypass is high, all 18 bits pass through as plain registered data and every error flag stays deasserted.

The block has no tri-state pads. Each side's outputs are given as a data vector plus a drive-enable flag, and that flag follows the output enable of the direction that feeds the side.

Top module: `regpar_xcvr`

## Requirements
- R1: While `rst_ni` is low, the storage of both directions clears to zero, with no clock needed. With the latch enable low, the stored bits of every lane then read as zero.
- R2: While a direction's latch enable is high, each lane's stored-path output equals that direction's input in the same cycle. The input is also written into storage at each rising clock edge.
- R3: With the latch enable low, a lane whose clock enable is high at a rising clock edge captures the input lane at that edge.
- R4: With the latch enable low, a lane whose clock enable is low keeps its stored value across clock edges, whatever the input does.
- R5: The two directions are independent. Controls and inputs of one direction have no effect on the stored values of the other.
- R6: Lane k occupies bits [9k+7:9k] for data and bit 9k+8 for parity. With `bypass_i` low, the output parity bit is the XOR of the eight stored data bits XOR `odd_i`. So with `odd_i`=1 the nine bits hold an odd count of ones, and with `odd_i`=0 an even count. The incoming parity bit does not reach the output.
- R7: With `bypass_i` low, a lane's error flag is 0 exactly when the XOR of its nine stored bits (data and incoming parity) differs from `odd_i`. `err_a_no` checks the stored A-to-B lanes and `err_b_no` checks the stored B-to-A lanes.
- R8: With `bypass_i` high, all nine stored bits of each lane, parity included, appear unchanged at the output, and every error flag is 1.
- R9: `b_oe_o` follows `oe_ab_i`, and `a_oe_o` follows `oe_ba_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | A-to-B storage clock |
| clk_ba_i | input | 1 | B-to-A storage clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | A bus input, two 9-bit lanes |
| b_i | input | 18 | B bus input, two 9-bit lanes |
| le_ab_i | input | 1 | A-to-B latch enable (high = transparent) |
| le_ba_i | input | 1 | B-to-A latch enable (high = transparent) |
| cke_ab_i | input | 2 | A-to-B clock enable, one per lane |
| cke_ba_i | input | 2 | B-to-A clock enable, one per lane |
| bypass_i | input | 1 | High disables parity logic |
| odd_i | input | 1 | Parity sense: 1 odd, 0 even |
| oe_ab_i | input | 1 | Output enable for B side drive |
| oe_ba_i | input | 1 | Output enable for A side drive |
| a_o | output | 18 | A bus output value |
| a_oe_o | output | 1 | A bus drive enable |
| b_o | output | 18 | B bus output value |
| b_oe_o | output | 1 | B bus drive enable |
| err_a_no | output | 2 | Per-lane parity error, A-to-B path, active low |
| err_b_no | output | 2 | Per-lane parity error, B-to-A path, active low |

## Verification
Captured and held values change only at the rising clock edge. Transparent data, regenerated parity, error flags and drive enables follow their controls in the same cycle, with no register on the way. The bench therefore drives every stimulus at the falling edge and updates its reference storage at the next rising edge. It samples all outputs 2 ns after that edge, so both the zero-cycle results and the one-edge results are compared in that single window. The asynchronous reset is checked with no edge at all, after a short settle time.

// File: rtl/regpar_pkg.sv
package regpar_pkg;
  typedef enum logic [1:0] {
    STG_HOLD    = 2'd0,
    STG_CAPTURE = 2'd1,
    STG_PASS    = 2'd2
  } stg_mode_e;

  // latch enable wins over lane clock enable
  function automatic stg_mode_e pick_mode(input logic le, input logic cke);
    if (le)       return STG_PASS;
    else if (cke) return STG_CAPTURE;
    else          return STG_HOLD;
  endfunction
endpackage

// File: rtl/regpar_stage.sv
module regpar_stage
  import regpar_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic         cke_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  stg_mode_e     mode;
  logic [W-1:0]  store_q;

  assign mode = pick_mode(le_i, cke_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               store_q <= '0;
    else if (mode != STG_HOLD) store_q <= d_i;
  end

  assign q_o = (mode == STG_PASS) ? d_i : store_q;
endmodule

// File: rtl/regpar_lane.sv
module regpar_lane #(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned SLOT_W = LANE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic              cke_i,
  input  logic              bypass_i,
  input  logic              odd_i,
  input  logic [SLOT_W-1:0] d_i,
  output logic [SLOT_W-1:0] q_o,
  output logic              err_no
);
  logic [SLOT_W-1:0] held;
  logic              gen_par;
  logic              bad_par;

  regpar_stage #(.W(SLOT_W)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_i),
    .cke_i  (cke_i),
    .d_i    (d_i),
    .q_o    (held)
  );

  assign gen_par = (^held[LANE_W-1:0]) ^ odd_i;
  assign bad_par = (^held) ^ odd_i;

  assign q_o    = bypass_i ? held : {gen_par, held[LANE_W-1:0]};
  assign err_no = bypass_i | ~bad_par;
endmodule

// File: rtl/regpar_dir.sv
module regpar_dir #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned SLOT_W = LANE_W + 1,
  localparam int unsigned BUS_W  = SLOT_W * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic [LANES-1:0] cke_i,
  input  logic             bypass_i,
  input  logic             odd_i,
  input  logic [BUS_W-1:0] d_i,
  output logic [BUS_W-1:0] q_o,
  output logic [LANES-1:0] err_no
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    regpar_lane #(.LANE_W(LANE_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .le_i     (le_i),
      .cke_i    (cke_i[k]),
      .bypass_i (bypass_i),
      .odd_i    (odd_i),
      .d_i      (d_i[k*SLOT_W +: SLOT_W]),
      .q_o      (q_o[k*SLOT_W +: SLOT_W]),
      .err_no   (err_no[k])
    );
  end
endmodule

// File: rtl/regpar_xcvr.sv
module regpar_xcvr #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned BUS_W = (LANE_W + 1) * LANES
) (
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] a_i,
  input  logic [BUS_W-1:0] b_i,
  input  logic             le_ab_i,
  input  logic             le_ba_i,
  input  logic [LANES-1:0] cke_ab_i,
  input  logic [LANES-1:0] cke_ba_i,
  input  logic             bypass_i,
  input  logic             odd_i,
  input  logic             oe_ab_i,
  input  logic             oe_ba_i,
  output logic [BUS_W-1:0] a_o,
  output logic             a_oe_o,
  output logic [BUS_W-1:0] b_o,
  output logic             b_oe_o,
  output logic [LANES-1:0] err_a_no,
  output logic [LANES-1:0] err_b_no
);
  regpar_dir #(.LANE_W(LANE_W), .LANES(LANES)) u_ab (
    .clk_i    (clk_ab_i),
    .rst_ni   (rst_ni),
    .le_i     (le_ab_i),
    .cke_i    (cke_ab_i),
    .bypass_i (bypass_i),
    .odd_i    (odd_i),
    .d_i      (a_i),
    .q_o      (b_o),
    .err_no   (err_a_no)
  );

  regpar_dir #(.LANE_W(LANE_W), .LANES(LANES)) u_ba (
    .clk_i    (clk_ba_i),
    .rst_ni   (rst_ni),
    .le_i     (le_ba_i),
    .cke_i    (cke_ba_i),
    .bypass_i (bypass_i),
    .odd_i    (odd_i),
    .d_i      (b_i),
    .q_o      (a_o),
    .err_no   (err_b_no)
  );

  assign b_oe_o = oe_ab_i;
  assign a_oe_o = oe_ba_i;
endmodule

// File: rtl/regpar_xcvr_chk.sv
module regpar_xcvr_chk #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned BUS_W = (LANE_W + 1) * LANES
) (
  input logic             clk_ab_i,
  input logic             clk_ba_i,
  input logic             rst_ni,
  input logic [BUS_W-1:0] a_i,
  input logic [BUS_W-1:0] b_i,
  input logic             le_ab_i,
  input logic             le_ba_i,
  input logic [LANES-1:0] cke_ab_i,
  input logic [LANES-1:0] cke_ba_i,
  input logic             bypass_i,
  input logic             odd_i,
  input logic [BUS_W-1:0] a_o,
  input logic [BUS_W-1:0] b_o,
  input logic [LANES-1:0] err_a_no,
  input logic [LANES-1:0] err_b_no
);
  assert_pass_ab_R2: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    le_ab_i |-> b_o[LANE_W-1:0] == a_i[LANE_W-1:0]);

  assert_pass_ba_R2: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    le_ba_i |-> a_o[LANE_W-1:0] == b_i[LANE_W-1:0]);

  assert_capture_ab_R3: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!le_ab_i && cke_ab_i[0]) && !le_ab_i)
      |-> b_o[LANE_W-1:0] == $past(a_i[LANE_W-1:0]));

  assert_hold_ab_R4: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    ($past(!le_ab_i && !cke_ab_i[0]) && !le_ab_i) |-> $stable(b_o[LANE_W-1:0]));

  assert_hold_ba_R4: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    ($past(!le_ba_i && !cke_ba_i[0]) && !le_ba_i) |-> $stable(a_o[LANE_W-1:0]));

  assert_gen_par_R6: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !bypass_i |-> b_o[LANE_W] == ((^b_o[LANE_W-1:0]) ^ odd_i));

  assert_bypass_err_R8: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    bypass_i |-> (&err_a_no) && (&err_b_no));
endmodule

bind regpar_xcvr regpar_xcvr_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk_ab_i (clk_ab_i),
  .clk_ba_i (clk_ba_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .b_i      (b_i),
  .le_ab_i  (le_ab_i),
  .le_ba_i  (le_ba_i),
  .cke_ab_i (cke_ab_i),
  .cke_ba_i (cke_ba_i),
  .bypass_i (bypass_i),
  .odd_i    (odd_i),
  .a_o      (a_o),
  .b_o      (b_o),
  .err_a_no (err_a_no),
  .err_b_no (err_b_no)
);

// File: tb/regpar_xcvr_bench.sv
`timescale 1ns/1ps
module regpar_xcvr_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] a_i = '0, b_i = '0;
  logic        le_ab = 1'b0, le_ba = 1'b0;
  logic [1:0]  cke_ab = '0, cke_ba = '0;
  logic        bypass = 1'b0, odd = 1'b0, oe_ab = 1'b0, oe_ba = 1'b0;
  logic [17:0] a_o, b_o;
  logic        a_oe, b_oe;
  logic [1:0]  err_a_n, err_b_n;

  logic [17:0] m_ab = '0, m_ba = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regpar_xcvr u_regpar_xcvr (
    .clk_ab_i (clk), .clk_ba_i (clk), .rst_ni (rst_ni),
    .a_i (a_i), .b_i (b_i), .le_ab_i (le_ab), .le_ba_i (le_ba),
    .cke_ab_i (cke_ab), .cke_ba_i (cke_ba), .bypass_i (bypass), .odd_i (odd),
    .oe_ab_i (oe_ab), .oe_ba_i (oe_ba), .a_o (a_o), .a_oe_o (a_oe),
    .b_o (b_o), .b_oe_o (b_oe), .err_a_no (err_a_n), .err_b_no (err_b_n)
  );

  // row: a[45:28] b[27:10] le_ab le_ba cke_ab[1:0] cke_ba[1:0] bypass odd oe_ab oe_ba
  localparam int NV = 10;
  localparam logic [45:0] TBL [NV] = '{
    {18'h2A5A5, 18'h11234, 10'b1_1_00_00_0_0_1_0},
    {18'h0F0F0, 18'h3C3C3, 10'b0_0_11_11_0_1_0_1},
    {18'h3FFFF, 18'h00000, 10'b0_0_00_00_0_0_1_1},
    {18'h12345, 18'h2BCDE, 10'b0_0_01_10_0_1_1_0},
    {18'h1FFFF, 18'h20000, 10'b1_0_00_11_1_0_1_1},
    {18'h30001, 18'h0FF00, 10'b0_1_10_00_1_1_0_0},
    {18'h00100, 18'h00001, 10'b1_1_00_00_0_1_1_1},
    {18'h2FF80, 18'h1AAAA, 10'b0_0_11_11_1_0_1_0},
    {18'h055AA, 18'h3E1E1, 10'b0_0_00_00_0_0_0_1},
    {18'h3C03C, 18'h00FF0, 10'b1_0_11_00_0_1_1_1}
  };

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic le, input logic cke);
    return le ? "R2" : (cke ? "R3" : "R4");
  endfunction

  task automatic compare_side(input logic [17:0] din, input logic [17:0] mq, input logic le,
                              input logic [1:0] cke, input logic [17:0] act,
                              input logic [1:0] err_act, input string side, input string note);
    logic [1:0] err_exp;
    for (int k = 0; k < 2; k++) begin
      logic [8:0] st, ex;
      st = le ? din[9*k +: 9] : mq[9*k +: 9];
      ex = st;
      if (!bypass) ex[8] = (^st[7:0]) ^ odd;
      err_exp[k] = bypass ? 1'b1 : ((^st) == odd);
      chk($sformatf("%s data %s lane%0d %s", mode_tag(le, cke[k]), side, k, note),
          {10'd0, act[9*k +: 8]}, {10'd0, ex[7:0]});
      chk($sformatf("%s parity %s lane%0d %s", bypass ? "R8" : "R6", side, k, note),
          {17'd0, act[9*k+8]}, {17'd0, ex[8]});
    end
    chk($sformatf("%s err %s %s", bypass ? "R8" : "R7", side, note),
        {16'd0, err_act}, {16'd0, err_exp});
  endtask

  task automatic compare_all(input string note);
    compare_side(a_i, m_ab, le_ab, cke_ab, b_o, err_a_n, "a2b", note);
    compare_side(b_i, m_ba, le_ba, cke_ba, a_o, err_b_n, "b2a", note);
    chk({"R9 b_oe ", note}, {17'd0, b_oe}, {17'd0, oe_ab});
    chk({"R9 a_oe ", note}, {17'd0, a_oe}, {17'd0, oe_ba});
  endtask

  task automatic apply(input logic [45:0] v, input string note);
    @(negedge clk);
    a_i = v[45:28]; b_i = v[27:10];
    {le_ab, le_ba, cke_ab, cke_ba, bypass, odd, oe_ab, oe_ba} = v[9:0];
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      if (le_ab || cke_ab[k]) m_ab[9*k +: 9] = a_i[9*k +: 9];
      if (le_ba || cke_ba[k]) m_ba[9*k +: 9] = b_i[9*k +: 9];
    end
    #2;
    compare_all(note);
  endtask

  initial begin
    // R1: reset with busy inputs, capture requested, bypass on
    a_i = 18'h3FFFF; b_i = 18'h3FFFF; cke_ab = 2'b11; cke_ba = 2'b11; bypass = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset b_o", b_o, 18'd0);
    chk("R1 reset a_o", a_o, 18'd0);
    @(negedge clk); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) apply(TBL[i], $sformatf("row%0d", i));

    // R5: A-to-B captures while B-to-A holds with changed input
    apply({18'h1B3C7, 18'h2D2D2, 10'b0_0_11_00_0_0_1_1}, "R5 ab_cap");
    apply({18'h1B3C7, 18'h0A0A0, 10'b0_0_00_11_0_1_1_1}, "R5 ba_cap");

    // R7: deliberately corrupted parity, both senses, transparent
    apply({18'h00000 | (18'd1 << 8), 18'h3FF00, 10'b1_1_00_00_0_0_1_1}, "R7 even_bad");
    apply({18'h00000 | (18'd1 << 8), 18'h3FF00, 10'b1_1_00_00_0_1_1_1}, "R7 odd_good");

    // R1: asynchronous reset mid-run, parity on, odd sense
    apply({18'h2AAAA, 18'h15555, 10'b0_0_00_00_0_1_1_1}, "pre_reset");
    #1 rst_ni = 1'b0;
    #1;
    m_ab = '0; m_ba = '0;
    compare_all("R1 async");
    chk("R1 async b_o", b_o, 18'h20100);
    @(negedge clk); rst_ni = 1'b1;
    apply({18'h3FFFF, 18'h3FFFF, 10'b0_0_00_00_0_1_1_1}, "R1 post_hold");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule